// File: doc/BRIEF.md
# Bang-Bang Fine Phase Tracking Controller

This block keeps a digitally controlled oscillator phase-aligned once the loop has finished acquiring frequency and phase. It runs once per reference cycle. Each cycle it takes a single early/late decision from an edge phase detector. If the oscillator clock is late, it raises the fine control word by the current step. If the clock is early, it lowers the word by the current step. The coarse control is not touched here.

The step starts at an initial gain and doubles every cycle while the decision keeps the same sign. When the sign of the decision reverses, the word and the step both snap back to the values that were latched when tracking was switched on. The fine word is also delivered as a thermometer code that drives a unit-weighted tuning array.

Control is a three-state machine:
- IDLE: tracking is off and the word is frozen. The transition *arm* is taken when the enable is seen high. It latches the initial word and gain, loads them, and moves to PRIME.
- PRIME: the first tracking cycle, for which no earlier decision exists. The transition *first step* applies one step, records the decision and moves to TRACK.
- TRACK: on the transition *continue* (same decision as last cycle) the block steps and doubles the gain. On the transition *flip* (opposite decision) it reloads the latched values and stays in TRACK.

From either PRIME or TRACK, the transition *disarm* (enable low) returns the machine to IDLE and leaves the word frozen.

Top module: `phase_track_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the fine word is 0 and every thermometer bit is 0.
- R2: With the enable low, the fine word holds its value on every clock whatever the decision and initial inputs are. When the enable is low in PRIME or TRACK, the machine returns to IDLE with the word unchanged.
- R3: The first clock edge that sees the enable high in IDLE loads the fine word with the initial word input. The same edge latches the initial word and the initial gain for later reloads.
- R4: In PRIME, and in TRACK when the decision equals the previous one, a decision of 1 (late) adds the current gain to the word and a decision of 0 (early) subtracts it.
- R5: Each stepping cycle the gain is shifted left by one bit, so consecutive steps of one polarity from gain 1 are 1, 2, 4, 8.
- R6: In TRACK, a decision differing from the previous cycle's loads the word with the latched initial word and the gain with the latched initial gain. It applies no step in that cycle. Changes on the initial inputs after the arm edge have no effect.
- R7: Stepping saturates: an up-step never goes above 63 (all ones), and a down-step never goes below 0.
- R8: Once the gain's most significant bit (value 32 for the 6-bit gain) is set, the gain stops shifting and keeps its value.
- R9: Thermometer bit i (bit 0 is the least significant) is 1 exactly when the fine word is greater than i, giving 63 bits for a 6-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trk_en | input | 1 | Enables maintenance tracking |
| pd_late | input | 1 | Phase decision: 1 oscillator late (raise word), 0 early (lower word) |
| init_word | input | 6 | Fine word latched and loaded on the arm edge |
| init_gain | input | 6 | Step size latched and loaded on the arm edge |
| fine_word | output | 6 | Registered fine control word |
| fine_therm | output | 63 | Thermometer code of fine_word |

## Verification
All word updates are due one clock edge after the inputs that cause them. The thermometer output follows the word with no further delay. The bench drives inputs on the falling edge. For each driven cycle it pushes one expected word, computed by a behavioural model of the requirements, into a queue. A monitor pops that entry just after the next rising edge and compares both the word and the full thermometer vector, so every expectation is checked against the exact edge that should produce it. Runs cover long same-polarity ramps, flips, reloads that ignore changed initial inputs, saturation at both ends, gain saturation and disarm/re-arm.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_TRACK = 2'd2
    } trk_state_t;
endpackage

// File: rtl/ptc_step.sv
module ptc_step #(
    parameter int WORD_W = 6
) (
    input  logic [WORD_W-1:0] cur_word,
    input  logic [WORD_W-1:0] step,
    input  logic              go_up,
    output logic [WORD_W-1:0] nxt_word
);
    localparam logic [WORD_W-1:0] WORD_MAX = {WORD_W{1'b1}};

    logic [WORD_W:0] sum_w;

    always_comb begin
        sum_w = {1'b0, cur_word} + {1'b0, step};
        if (go_up) begin
            nxt_word = sum_w[WORD_W] ? WORD_MAX : sum_w[WORD_W-1:0];
        end else begin
            nxt_word = (step > cur_word) ? '0 : (cur_word - step);
        end
    end
endmodule

// File: rtl/ptc_gain.sv
module ptc_gain #(
    parameter int GAIN_W = 6
) (
    input  logic [GAIN_W-1:0] cur_gain,
    output logic [GAIN_W-1:0] nxt_gain
);
    always_comb begin
        if (cur_gain[GAIN_W-1]) begin
            nxt_gain = cur_gain;
        end else begin
            nxt_gain = {cur_gain[GAIN_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/ptc_therm.sv
module ptc_therm #(
    parameter int WORD_W = 6,
    localparam int TH_W = (1 << WORD_W) - 1
) (
    input  logic [WORD_W-1:0] word,
    output logic [TH_W-1:0]   therm
);
    for (genvar i = 0; i < TH_W; i++) begin : g_bit
        localparam logic [WORD_W-1:0] IDX = WORD_W'(i);
        assign therm[i] = (word > IDX);
    end

    // R9
    always_comb begin
        therm_count_chk: assert ($countones(therm) == int'(word))
            else $error("thermometer population differs from word");
    end
endmodule

// File: rtl/phase_track_ctrl.sv
module phase_track_ctrl #(
    parameter int WORD_W = 6,
    parameter int GAIN_W = WORD_W,
    localparam int TH_W = (1 << WORD_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trk_en,
    input  logic              pd_late,
    input  logic [WORD_W-1:0] init_word,
    input  logic [GAIN_W-1:0] init_gain,
    output logic [WORD_W-1:0] fine_word,
    output logic [TH_W-1:0]   fine_therm
);
    import ptc_pkg::*;

    trk_state_t        state_q, state_d;
    logic [WORD_W-1:0] word_q, word_d, sv_word_q, sv_word_d;
    logic [GAIN_W-1:0] gain_q, gain_d, sv_gain_q, sv_gain_d;
    logic              prev_q, prev_d;
    logic [WORD_W-1:0] stepped_word;
    logic [GAIN_W-1:0] grown_gain;
    logic              flip;

    ptc_step #(.WORD_W(WORD_W)) u_step (
        .cur_word (word_q),
        .step     (WORD_W'(gain_q)),
        .go_up    (pd_late),
        .nxt_word (stepped_word)
    );

    ptc_gain #(.GAIN_W(GAIN_W)) u_gain (
        .cur_gain (gain_q),
        .nxt_gain (grown_gain)
    );

    ptc_therm #(.WORD_W(WORD_W)) u_therm (
        .word  (word_q),
        .therm (fine_therm)
    );

    assign flip = (state_q == ST_TRACK) && (pd_late != prev_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and datapath updates
    always_comb begin
        state_d   = state_q;
        word_d    = word_q;
        gain_d    = gain_q;
        prev_d    = prev_q;
        sv_word_d = sv_word_q;
        sv_gain_d = sv_gain_q;
        if (!trk_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sv_word_d = init_word;
                    sv_gain_d = init_gain;
                    word_d    = init_word;
                    gain_d    = init_gain;
                    state_d   = ST_PRIME;
                end
                ST_PRIME: begin
                    word_d  = stepped_word;
                    gain_d  = grown_gain;
                    prev_d  = pd_late;
                    state_d = ST_TRACK;
                end
                ST_TRACK: begin
                    prev_d = pd_late;
                    if (flip) begin
                        word_d = sv_word_q;
                        gain_d = sv_gain_q;
                    end else begin
                        word_d = stepped_word;
                        gain_d = grown_gain;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            gain_q    <= '0;
            prev_q    <= 1'b0;
            sv_word_q <= '0;
            sv_gain_q <= '0;
        end else begin
            word_q    <= word_d;
            gain_q    <= gain_d;
            prev_q    <= prev_d;
            sv_word_q <= sv_word_d;
            sv_gain_q <= sv_gain_d;
        end
    end

    assign fine_word = word_q;

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trk_en |=> $stable(fine_word));

    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_en && state_q != ST_IDLE && !flip && pd_late) |=> fine_word >= $past(fine_word));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_en && state_q != ST_IDLE && !flip && !pd_late) |=> fine_word <= $past(fine_word));

    // R6
    flip_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_en && flip) |=> (fine_word == sv_word_q) && (gain_q == sv_gain_q));

    // R8
    gain_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_en && state_q != ST_IDLE && !flip && gain_q[GAIN_W-1]) |=> $stable(gain_q));

    // R3
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_en && state_q == ST_IDLE) |=> (fine_word == $past(init_word)) && (state_q == ST_PRIME));
endmodule

// File: tb/phase_track_ctrl_tb.sv
module phase_track_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WW = 6;
    localparam int TW = (1 << WW) - 1;
    localparam int WMAX = TW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trk_en = 1'b0;
    logic          pd_late = 1'b0;
    logic [WW-1:0] init_word = '0;
    logic [WW-1:0] init_gain = '0;
    logic [WW-1:0] fine_word;
    logic [TW-1:0] fine_therm;

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    string tag_q[$];

    // behavioural model
    int m_state = 0;
    int m_word = 0, m_gain = 0, m_sw = 0, m_sg = 0, m_prev = 0;

    phase_track_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .trk_en     (trk_en),
        .pd_late    (pd_late),
        .init_word  (init_word),
        .init_gain  (init_gain),
        .fine_word  (fine_word),
        .fine_therm (fine_therm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [TW-1:0] therm_of(int w);
        logic [TW-1:0] t;
        for (int i = 0; i < TW; i++) t[i] = (w > i);
        return t;
    endfunction

    task automatic check(string tag, int act, int expv, logic [TW-1:0] act_t, logic [TW-1:0] exp_t);
        n_chk++;
        if (act != expv || act_t != exp_t) begin
            n_fail++;
            $display("FAIL %s word=%0d exp=%0d therm=%h exp_therm=%h", tag, act, expv, act_t, exp_t);
        end
    endtask

    task automatic model_step(int pd);
        if (pd != 0) m_word = (m_word + m_gain > WMAX) ? WMAX : m_word + m_gain;
        else         m_word = (m_gain > m_word) ? 0 : m_word - m_gain;
        if (m_gain < 32) m_gain = m_gain * 2;
    endtask

    // driver: one reference cycle
    task automatic cyc(bit en, bit pd, int iw, int ig, string tag);
        @(negedge clk);
        trk_en    = en;
        pd_late   = pd;
        init_word = WW'(iw);
        init_gain = WW'(ig);
        if (!en) begin
            m_state = 0;
        end else if (m_state == 0) begin
            m_sw = iw; m_sg = ig; m_word = iw; m_gain = ig; m_state = 1;
        end else if (m_state == 1) begin
            model_step(int'(pd)); m_prev = int'(pd); m_state = 2;
        end else begin
            if (int'(pd) != m_prev) begin
                m_word = m_sw; m_gain = m_sg;
            end else begin
                model_step(int'(pd));
            end
            m_prev = int'(pd);
        end
        exp_q.push_back(m_word);
        tag_q.push_back(tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(fine_word), e, fine_therm, therm_of(e));
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", int'(fine_word), 0, fine_therm, '0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 1, 40, 3, "R1 after reset");
        cyc(0, 0, 50, 5, "R2 idle hold");
        // arm and ramp up
        cyc(1, 1, 32, 1, "R3 arm load");
        cyc(1, 1, 9, 9, "R4 first up step");
        cyc(1, 1, 9, 9, "R5 gain 2");
        cyc(1, 1, 9, 9, "R5 gain 4");
        cyc(1, 1, 9, 9, "R5 gain 8");
        cyc(1, 0, 9, 9, "R6 flip reload");
        cyc(1, 0, 9, 9, "R4 down step");
        cyc(1, 0, 9, 9, "R5 down gain 2");
        cyc(1, 1, 9, 9, "R6 flip back");
        // disarm freezes
        cyc(0, 1, 1, 1, "R2 disarm hold");
        cyc(0, 0, 2, 2, "R2 still held");
        // top saturation
        cyc(1, 1, 60, 4, "R3 rearm");
        cyc(1, 1, 0, 0, "R7 sat high");
        cyc(1, 1, 0, 0, "R7 stay high");
        cyc(1, 0, 0, 0, "R6 reload latched");
        cyc(0, 0, 0, 0, "R2 disarm");
        // bottom saturation
        cyc(1, 0, 2, 4, "R3 rearm low");
        cyc(1, 0, 0, 0, "R7 sat low");
        cyc(1, 0, 0, 0, "R7 stay low");
        cyc(0, 0, 0, 0, "R2 disarm");
        // gain saturation
        cyc(1, 1, 0, 3, "R3 arm gain3");
        for (int k = 0; k < 3; k++) cyc(1, 1, 0, 0, "R8 ramp");
        cyc(1, 0, 0, 0, "R6 flip");
        cyc(1, 0, 63, 3, "R6 ahead");
        cyc(0, 0, 0, 0, "R2 disarm");
        cyc(1, 0, 63, 16, "R3 arm 63");
        cyc(1, 0, 0, 0, "R4 gain16");
        cyc(1, 0, 0, 0, "R8 gain32");
        cyc(1, 0, 0, 0, "R8 gain held");
        cyc(1, 0, 0, 0, "R9 therm at zero");
        cyc(0, 0, 0, 0, "R2 disarm");
        cyc(1, 1, 21, 1, "R9 therm mid");
        cyc(1, 1, 0, 0, "R9 therm step");
        repeat (3) @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule